// File: doc/BRIEF.md
# DMA Slave Request/Acknowledge Controller

This block is the slave side of a request/acknowledge DMA link. An external DMA master watches a request line from the block and answers with an acknowledge line; every acknowledged cycle moves one 16-bit word from or to a local buffer memory. The block holds two channels that run independently of each other, one for the host-side function and one for the device-side function. Each channel has its own configuration, length registers, request and acknowledge pins, buffer strobe and end-of-transfer interrupt.

Software sets up a channel and then pulses its start input. The channel loads a byte count, raises its request while bytes remain, steps the buffer word address from zero on every acknowledged word, and lowers the request in the same clock as the final acknowledge. The source of the byte count depends on the addressing mode. In direct mode the count comes from a separate length register, and the transfer-count register must hold exactly one; any other value flags a configuration error and no transfer starts. When the last word has moved, a sticky completion flag is set. That flag drives the interrupt output when the interrupt is enabled.

The line polarities and the acknowledge counting mode are programmable per channel. The acknowledge can count by level, one word per clock, or by edge, one word per assertion.

Top module: `dma_slave_ctrl`

## Requirements
- R1: The block has NCH (default 2) channels. Each channel has its own configuration, pins, counter and interrupt, and activity on one channel never changes the outputs of another.
- R2: Bit 3 of the channel's DMA configuration word selects the addressing mode. When it is 1 (direct), the byte count loaded at start comes from the direct-length input. When it is 0 (indirect), the count comes from the transfer-count input and the direct-length input is ignored.
- R3: A start in direct mode while the transfer-count input is not 1 sets the channel's config-error output and loads a count of zero, so no request is raised. The next start clears the error.
- R4: Bit 5 of the hardware configuration word sets the request pin polarity (1 = active high, 0 = active low). Bit 6 sets the acknowledge pin polarity the same way.
- R5: The request pin is at its active level while the remaining count is nonzero. It is at its inactive level after reset and after a start with a zero count.
- R6: Each accepted acknowledge pulses the buffer strobe for one clock, presents the current word address (0 for the first word after a start, then +1 per word), and takes 2 bytes off the remaining count. An odd count rounds up to a final whole word. A new start reloads the count and returns the address to 0.
- R7: Bit 8 of the hardware configuration word selects the acknowledge mode. At 0, every clock with the acknowledge active moves one word. At 1, only the clock where the acknowledge becomes active moves a word, however long it is held.
- R8: The request pin goes to its inactive level combinationally in the same clock in which the last word is acknowledged.
- R9: The clock after the last word, the channel's completion flag is set. The interrupt output equals that flag ANDed with bit 3 of the channel's interrupt-enable word. The flag is set whether or not the interrupt is enabled.
- R10: The completion flag stays set until a pulse on the channel's clear input (write-one-to-clear). If a completion and a clear happen in the same clock, the completion wins.
- R11: An acknowledge while the channel has nothing left to move produces no strobe and leaves the word address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hw_cfg_i | input | NCH x 16 | Hardware configuration per channel: bit 5 request polarity, bit 6 acknowledge polarity, bit 8 acknowledge mode |
| dma_cfg_i | input | NCH x 4 | DMA configuration per channel: bit 3 addressing mode |
| int_en_i | input | NCH x 8 | Interrupt enable per channel: bit 3 completion interrupt |
| dir_len_i | input | NCH x LEN_W | Byte count used in direct mode |
| xfer_cnt_i | input | NCH x LEN_W | Transfer-count register: byte count in indirect mode, must be 1 in direct mode |
| start_i | input | NCH | One-clock pulse that loads the count and resets the word address |
| irq_clr_i | input | NCH | One-clock pulse that clears the completion flag |
| dack_i | input | NCH | Acknowledge pins from the DMA master |
| dreq_o | output | NCH | Request pins to the DMA master |
| irq_o | output | NCH | Completion interrupt per channel |
| cfg_err_o | output | NCH | Direct-mode configuration error per channel |
| mem_strobe_o | output | NCH | Buffer word access strobe per channel |
| mem_addr_o | output | NCH x ADDR_W | Buffer word address per channel |

## Verification
The bench targets the final acknowledge. If the request is dropped a clock late, the master sees one more request than there is data; the bench catches this by checking the request pin in the same clock as the last strobe. Holding the acknowledge for two clocks in edge mode exposes a design that counts by level and would move too many words. Odd byte counts and zero counts catch a counter that underflows and keeps requesting. A direct-mode start with a bad transfer count, and an indirect start with a stray direct length, catch a design that reads the length from the wrong register. The completion flag is left unattended for several clocks, then cleared, and it is also latched with the interrupt masked. This catches a flag that is pulsed instead of held, or one that is gated before it is stored.

// File: rtl/dma_slv_pkg.sv
package dma_slv_pkg;

    localparam int HW_W  = 16;
    localparam int DCFG_W = 4;
    localparam int IE_W  = 8;

    localparam int HW_REQ_POL_BIT  = 5;
    localparam int HW_ACK_POL_BIT  = 6;
    localparam int HW_ACK_MODE_BIT = 8;
    localparam int DCFG_DIRECT_BIT = 3;
    localparam int IE_EOT_BIT      = 3;

    typedef enum logic {
        ACK_LEVEL = 1'b0,
        ACK_EDGE  = 1'b1
    } ack_mode_e;

    typedef struct packed {
        logic      req_high;
        logic      ack_high;
        ack_mode_e ack_mode;
        logic      direct;
        logic      eot_en;
    } chan_cfg_t;

    function automatic chan_cfg_t decode_cfg(
        input logic [HW_W-1:0]   hw,
        input logic [DCFG_W-1:0] dc,
        input logic [IE_W-1:0]   ie
    );
        chan_cfg_t c;
        c.req_high = hw[HW_REQ_POL_BIT];
        c.ack_high = hw[HW_ACK_POL_BIT];
        c.ack_mode = ack_mode_e'(hw[HW_ACK_MODE_BIT]);
        c.direct   = dc[DCFG_DIRECT_BIT];
        c.eot_en   = ie[IE_EOT_BIT];
        return c;
    endfunction

endpackage

// File: rtl/dma_len_select.sv
module dma_len_select #(
    parameter int LEN_W = 16
) (
    input  logic             direct,
    input  logic [LEN_W-1:0] dir_len,
    input  logic [LEN_W-1:0] xfer_cnt,
    output logic [LEN_W-1:0] load_len,
    output logic             bad_cfg
);
    always_comb begin
        bad_cfg = direct && (xfer_cnt != LEN_W'(1));
        if (bad_cfg)
            load_len = '0;
        else if (direct)
            load_len = dir_len;
        else
            load_len = xfer_cnt;
    end
endmodule

// File: rtl/dma_ack_detect.sv
module dma_ack_detect
    import dma_slv_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      dack_pin,
    input  logic      ack_high,
    input  ack_mode_e ack_mode,
    input  logic      enable,
    output logic      ack_event
);
    logic level_on;
    logic prev_on;

    assign level_on = (dack_pin == ack_high);

    always_ff @(posedge clk) begin
        if (rst)
            prev_on <= 1'b0;
        else
            prev_on <= level_on;
    end

    always_comb begin
        if (ack_mode == ACK_EDGE)
            ack_event = enable && level_on && !prev_on;
        else
            ack_event = enable && level_on;
    end

    // R7: edge mode never accepts two words on consecutive clocks
    a_r7_edge_single: assert property (@(posedge clk) disable iff (rst)
        (ack_event && ack_mode == ACK_EDGE) |=> (!ack_event || ack_mode != ACK_EDGE));
endmodule

// File: rtl/dma_chan.sv
module dma_chan
    import dma_slv_pkg::*;
#(
    parameter int LEN_W  = 16,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  chan_cfg_t         cfg,
    input  logic [LEN_W-1:0]  dir_len,
    input  logic [LEN_W-1:0]  xfer_cnt,
    input  logic              start,
    input  logic              irq_clr,
    input  logic              dack,
    output logic              dreq,
    output logic              irq,
    output logic              cfg_err,
    output logic              mem_strobe,
    output logic [ADDR_W-1:0] mem_addr
);
    localparam logic [LEN_W-1:0] WORD_BYTES = LEN_W'(2);

    logic [LEN_W-1:0]  remaining;
    logic [ADDR_W-1:0] word_addr;
    logic [LEN_W-1:0]  load_len;
    logic              bad_cfg;
    logic              busy;
    logic              ack_event;
    logic              last_word;
    logic              req_act;
    logic              eot_sts;

    dma_len_select #(.LEN_W(LEN_W)) u_len (
        .direct   (cfg.direct),
        .dir_len  (dir_len),
        .xfer_cnt (xfer_cnt),
        .load_len (load_len),
        .bad_cfg  (bad_cfg)
    );

    assign busy = (remaining != '0);

    dma_ack_detect u_ack (
        .clk       (clk),
        .rst       (rst),
        .dack_pin  (dack),
        .ack_high  (cfg.ack_high),
        .ack_mode  (cfg.ack_mode),
        .enable    (busy && !start),
        .ack_event (ack_event)
    );

    assign last_word = ack_event && (remaining <= WORD_BYTES);
    assign req_act   = busy && !last_word;

    always_ff @(posedge clk) begin
        if (rst) begin
            remaining <= '0;
            word_addr <= '0;
            cfg_err   <= 1'b0;
        end else if (start) begin
            remaining <= load_len;
            word_addr <= '0;
            cfg_err   <= bad_cfg;
        end else if (ack_event) begin
            remaining <= last_word ? '0 : remaining - WORD_BYTES;
            word_addr <= word_addr + ADDR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            eot_sts <= 1'b0;
        else if (last_word)
            eot_sts <= 1'b1;
        else if (irq_clr)
            eot_sts <= 1'b0;
    end

    assign dreq       = cfg.req_high ? req_act : !req_act;
    assign irq        = eot_sts && cfg.eot_en;
    assign mem_strobe = ack_event;
    assign mem_addr   = word_addr;

    // R6: each accepted word removes two bytes, saturating at zero
    a_r6_count_step: assert property (@(posedge clk) disable iff (rst)
        ack_event |=> remaining == (($past(remaining) > WORD_BYTES) ?
                                     $past(remaining) - WORD_BYTES : '0));

    // R6: each accepted word advances the buffer address by one
    a_r6_addr_step: assert property (@(posedge clk) disable iff (rst)
        ack_event |=> word_addr == $past(word_addr) + ADDR_W'(1));

    // R11: an idle channel keeps its address and count
    a_r11_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> (remaining == '0 && $stable(word_addr)));

    // R3: a bad direct-mode setup raises the error and never requests
    a_r3_bad_direct: assert property (@(posedge clk) disable iff (rst)
        (start && cfg.direct && xfer_cnt != LEN_W'(1)) |=> (cfg_err && !busy));

    // R9: the final word sets the completion flag
    a_r9_eot_set: assert property (@(posedge clk) disable iff (rst)
        last_word |=> eot_sts);

    // R10: the completion flag holds until a clear
    a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
        (eot_sts && !irq_clr) |=> eot_sts);
endmodule

// File: rtl/dma_slave_ctrl.sv
module dma_slave_ctrl
    import dma_slv_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int LEN_W  = 16,
    parameter int ADDR_W = 10
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NCH-1:0][HW_W-1:0]    hw_cfg_i,
    input  logic [NCH-1:0][DCFG_W-1:0]  dma_cfg_i,
    input  logic [NCH-1:0][IE_W-1:0]    int_en_i,
    input  logic [NCH-1:0][LEN_W-1:0]   dir_len_i,
    input  logic [NCH-1:0][LEN_W-1:0]   xfer_cnt_i,
    input  logic [NCH-1:0]              start_i,
    input  logic [NCH-1:0]              irq_clr_i,
    input  logic [NCH-1:0]              dack_i,
    output logic [NCH-1:0]              dreq_o,
    output logic [NCH-1:0]              irq_o,
    output logic [NCH-1:0]              cfg_err_o,
    output logic [NCH-1:0]              mem_strobe_o,
    output logic [NCH-1:0][ADDR_W-1:0]  mem_addr_o
);
    // R1: one independent engine per channel
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        chan_cfg_t cfg;
        assign cfg = decode_cfg(hw_cfg_i[c], dma_cfg_i[c], int_en_i[c]);

        dma_chan #(
            .LEN_W  (LEN_W),
            .ADDR_W (ADDR_W)
        ) u_chan (
            .clk        (clk),
            .rst        (rst),
            .cfg        (cfg),
            .dir_len    (dir_len_i[c]),
            .xfer_cnt   (xfer_cnt_i[c]),
            .start      (start_i[c]),
            .irq_clr    (irq_clr_i[c]),
            .dack       (dack_i[c]),
            .dreq       (dreq_o[c]),
            .irq        (irq_o[c]),
            .cfg_err    (cfg_err_o[c]),
            .mem_strobe (mem_strobe_o[c]),
            .mem_addr   (mem_addr_o[c])
        );
    end
endmodule

// File: tb/dma_slave_ctrl_test.sv
module dma_slave_ctrl_test;
    localparam int NCH = 2;
    localparam int LEN_W = 16;
    localparam int ADDR_W = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NCH-1:0][15:0]      hw_cfg = '0;
    logic [NCH-1:0][3:0]       dma_cfg = '0;
    logic [NCH-1:0][7:0]       int_en = '0;
    logic [NCH-1:0][LEN_W-1:0] dir_len = '0;
    logic [NCH-1:0][LEN_W-1:0] xfer_cnt = '0;
    logic [NCH-1:0]            start = '0;
    logic [NCH-1:0]            irq_clr = '0;
    logic [NCH-1:0]            dack = '1;
    logic [NCH-1:0]            dreq;
    logic [NCH-1:0]            irq;
    logic [NCH-1:0]            cfg_err;
    logic [NCH-1:0]            mem_strobe;
    logic [NCH-1:0][ADDR_W-1:0] mem_addr;

    int n_checks = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    dma_slave_ctrl #(.NCH(NCH), .LEN_W(LEN_W), .ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst(rst), .hw_cfg_i(hw_cfg), .dma_cfg_i(dma_cfg),
        .int_en_i(int_en), .dir_len_i(dir_len), .xfer_cnt_i(xfer_cnt),
        .start_i(start), .irq_clr_i(irq_clr), .dack_i(dack),
        .dreq_o(dreq), .irq_o(irq), .cfg_err_o(cfg_err),
        .mem_strobe_o(mem_strobe), .mem_addr_o(mem_addr)
    );

    typedef struct packed {
        int ch; bit rq; bit ak; bit edge_m; bit direct;
        int dlen; int xcnt; bit ien; int words; bit err;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{0, 1'b1, 1'b1, 1'b0, 1'b0,  0, 8, 1'b1, 4, 1'b0},
        '{1, 1'b0, 1'b0, 1'b0, 1'b0,  0, 6, 1'b0, 3, 1'b0},
        '{0, 1'b1, 1'b0, 1'b1, 1'b1, 10, 1, 1'b1, 5, 1'b0},
        '{1, 1'b0, 1'b1, 1'b1, 1'b1,  4, 1, 1'b1, 2, 1'b0},
        '{0, 1'b1, 1'b1, 1'b0, 1'b1, 12, 2, 1'b1, 0, 1'b1},
        '{1, 1'b1, 1'b1, 1'b0, 1'b0,  0, 5, 1'b1, 3, 1'b0},
        '{0, 1'b0, 1'b1, 1'b0, 1'b0,  0, 0, 1'b1, 0, 1'b0},
        '{0, 1'b1, 1'b1, 1'b1, 1'b0, 99, 2, 1'b1, 1, 1'b0}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_cfg(input int ch, input bit rq, input bit ak, input bit edge_m,
                           input bit direct, input int dl, input int xc, input bit ien);
        @(negedge clk);
        hw_cfg[ch]   = 16'((int'(rq) << 5) | (int'(ak) << 6) | (int'(edge_m) << 8));
        dma_cfg[ch]  = 4'(int'(direct) << 3);
        int_en[ch]   = 8'(int'(ien) << 3);
        dir_len[ch]  = LEN_W'(dl);
        xfer_cnt[ch] = LEN_W'(xc);
        dack[ch]     = ~ak;
        @(negedge clk);
    endtask

    task automatic pulse_start(input int ch);
        @(negedge clk); start[ch] = 1'b1;
        @(negedge clk); start[ch] = 1'b0;
    endtask

    task automatic pulse_clr(input int ch);
        @(negedge clk); irq_clr[ch] = 1'b1;
        @(negedge clk); irq_clr[ch] = 1'b0;
    endtask

    // Drives acknowledges until the request falls; counts strobes.
    task automatic run_acks(input int ch, input bit rq, input bit ak, input bit edge_m,
                            output int words, output bit same_drop);
        words = 0;
        same_drop = 1'b0;
        #1;
        if (dreq[ch] != rq) return;
        for (int it = 0; it < 64; it++) begin
            dack[ch] = ak;
            #1;
            if (mem_strobe[ch]) begin
                chk(int'(mem_addr[ch]) == words, "R6 word address", int'(mem_addr[ch]), words);
                words++;
                if (dreq[ch] != rq) begin
                    same_drop = 1'b1;
                    break;
                end
            end else begin
                chk(1'b0, "R7 expected a strobe on acknowledge", 0, 1);
            end
            @(negedge clk);
            if (edge_m) begin
                #1;
                chk(!mem_strobe[ch], "R7 edge mode held acknowledge", int'(mem_strobe[ch]), 0);
                @(negedge clk);
                dack[ch] = ~ak;
                @(negedge clk);
            end
        end
        @(negedge clk);
        dack[ch] = ~ak;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int w;
        bit sd;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        // R5: reset leaves requests inactive (active-low default, idle high)
        chk(dreq == 2'b11, "R5 reset request level", int'(dreq), 3);
        chk(irq == 2'b00 && cfg_err == 2'b00, "R9 reset irq/err", int'({irq, cfg_err}), 0);
        chk(mem_strobe == 2'b00 && mem_addr[0] == '0, "R6 reset strobe/address", int'(mem_strobe), 0);

        for (int v = 0; v < NV; v++) begin
            vec_t t;
            t = VEC[v];
            set_cfg(t.ch, t.rq, t.ak, t.edge_m, t.direct, t.dlen, t.xcnt, t.ien);
            pulse_clr(t.ch);
            #1;
            chk(irq[t.ch] == 1'b0, "R10 clear", int'(irq[t.ch]), 0);
            chk(dreq[t.ch] == ~t.rq, "R4 idle request polarity", int'(dreq[t.ch]), int'(~t.rq));
            pulse_start(t.ch);
            run_acks(t.ch, t.rq, t.ak, t.edge_m, w, sd);
            // R2 length source, R6 rounding, R7 mode
            chk(w == t.words, "R2 words moved", w, t.words);
            if (t.words > 0)
                chk(sd, "R8 request drop with last word", int'(sd), 1);
            @(negedge clk); #1;
            chk(irq[t.ch] == (t.ien && t.words > 0), "R9 completion interrupt",
                int'(irq[t.ch]), int'(t.ien && t.words > 0));
            chk(cfg_err[t.ch] == t.err, "R3 config error", int'(cfg_err[t.ch]), int'(t.err));
            chk(dreq[t.ch] == ~t.rq, "R5 request idle after transfer", int'(dreq[t.ch]), int'(~t.rq));
        end

        // R10: flag holds with no clear, then clears
        repeat (5) @(negedge clk);
        #1;
        chk(irq[0] == 1'b1, "R10 sticky flag", int'(irq[0]), 1);
        pulse_clr(0);
        #1;
        chk(irq[0] == 1'b0, "R10 write-one clear", int'(irq[0]), 0);

        // R11: acknowledge on an idle channel does nothing
        dack[0] = 1'b1;
        repeat (3) begin
            @(negedge clk); #1;
            chk(!mem_strobe[0] && mem_addr[0] == ADDR_W'(1), "R11 idle acknowledge",
                int'(mem_addr[0]), 1);
        end
        dack[0] = 1'b0;

        // R9: flag latched while interrupt masked, visible once enabled
        set_cfg(1, 1'b1, 1'b1, 1'b0, 1'b0, 0, 2, 1'b0);
        pulse_clr(1);
        pulse_start(1);
        run_acks(1, 1'b1, 1'b1, 1'b0, w, sd);
        @(negedge clk); #1;
        chk(irq[1] == 1'b0, "R9 masked interrupt", int'(irq[1]), 0);
        int_en[1] = 8'h08;
        #1;
        chk(irq[1] == 1'b1, "R9 flag set while masked", int'(irq[1]), 1);

        // R1 and R6: restart mid-transfer on channel 0; channel 1 stays idle
        set_cfg(0, 1'b1, 1'b1, 1'b0, 1'b0, 0, 8, 1'b1);
        pulse_start(0);
        #1;
        chk(dreq[0] == 1'b1 && dreq[1] == 1'b0, "R1 channel independence", int'(dreq), 1);
        dack[0] = 1'b1;
        #1;
        chk(mem_strobe == 2'b01, "R1 strobe only on channel 0", int'(mem_strobe), 1);
        @(negedge clk);
        dack[0] = 1'b0;
        #1;
        chk(mem_addr[0] == ADDR_W'(1), "R6 address after one word", int'(mem_addr[0]), 1);
        pulse_start(0);
        #1;
        chk(mem_addr[0] == '0, "R6 restart address", int'(mem_addr[0]), 0);
        run_acks(0, 1'b1, 1'b1, 1'b0, w, sd);
        chk(w == 4, "R6 restart reloads count", w, 4);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule